// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Edge Events

This block is a 32-pin general-purpose I/O controller that sits on a simple single-cycle register bus. Software sets each pin's direction and open-drain behaviour and writes the output levels. It reads back either the level driven onto an output pin or the synchronized level on an input pin. Every pin passes through a two-stage synchronizer. The synchronized level then feeds a per-pin edge detector, which records events in a sticky event register.

Each pin can sense falling edges only or any edge. An event register bit is cleared by writing one to it. A mask register decides which latched events reach the single interrupt output. Inside every register, pin n occupies bit 31-n, so pin 0 is the most significant bit. The pad-side vectors are indexed by pin number. Writes take effect at the next clock edge, and read data is combinational from the address.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads zero, no pad output enable is active and the interrupt output is low.
- R2: Register bit 31-n belongs to pin n, and pad vector bit n belongs to pin n. For example, bit 31 of any register controls or reports pad bit 0.
- R3: A direction bit of 1 enables the pad driver of that pin. A direction bit of 0 keeps its output enable low.
- R4: For an output pin whose open-drain bit is 1, data 0 drives the pad low with the enable active, and data 1 releases the pad. With the open-drain bit at 0, the pad value follows the data bit.
- R5: Reading the data register (offset 0x08) returns the stored data bit for output pins. For input pins it returns the pad level sampled two clock edges earlier.
- R6: With its interrupt-control bit at 0, a pin latches an event on both rising and falling synchronized edges. The event bit reads as set after the third clock edge following the pad change.
- R7: With its interrupt-control bit at 1, a pin latches events only on falling edges, and rising edges leave its event bit unchanged.
- R8: Writing the event register (offset 0x0C) clears each bit written as 1 and keeps each bit written as 0. Without such a clear, a set event bit stays set.
- R9: An edge detected in the same cycle as a clear of that pin's event bit leaves the bit set.
- R10: The interrupt output is high exactly when some bit is set in both the event register and the mask register (offset 0x10).
- R11: The direction (0x00), open-drain (0x04), mask (0x10) and interrupt-control (0x14) registers read back the value last written. Writes to any other offset change nothing, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pad input levels, bit n = pin n |
| pad_out | output | 32 | Pad output values, bit n = pin n |
| pad_oe | output | 32 | Pad output enables, bit n = pin n |
| irq | output | 1 | Combined interrupt |

## Verification
Directed patterns come first. A single output pin driven in push-pull and in open-drain mode separates R3 from R4. A lone high input on the last pin shows whether the bit order is reversed and whether the two-edge synchronizer latency is right. A rise followed by a fall on one pin in each sensing mode separates any-edge from falling-only detection. A clear issued in exactly the cycle an edge lands shows whether the edge or the clear wins.

A long random phase then mixes writes to every offset, including unmapped ones, with random pad toggles. A behavioural model built on a history of pad samples is compared against all outputs on every cycle. This exposes wrong latencies, lost sticky bits and masking errors that the directed patterns might miss.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam logic [7:0] OFS_DIR = 8'h00;
  localparam logic [7:0] OFS_OD  = 8'h04;
  localparam logic [7:0] OFS_DAT = 8'h08;
  localparam logic [7:0] OFS_EVT = 8'h0C;
  localparam logic [7:0] OFS_MSK = 8'h10;
  localparam logic [7:0] OFS_CTL = 8'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_OD,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_CTL,
    SEL_NONE
  } gpio_sel_e;

  // Map a byte offset onto a register select; anything unlisted selects nothing.
  function automatic gpio_sel_e decode_sel(input logic [7:0] ofs);
    case (ofs)
      OFS_DIR: return SEL_DIR;
      OFS_OD:  return SEL_OD;
      OFS_DAT: return SEL_DAT;
      OFS_EVT: return SEL_EVT;
      OFS_MSK: return SEL_MSK;
      OFS_CTL: return SEL_CTL;
      default: return SEL_NONE;
    endcase
  endfunction

  // Edge qualification for one pin: falls always count, rises only in any-edge mode.
  function automatic logic edge_hit(input logic cur, input logic prv, input logic fall_only);
    return (prv & ~cur) | (~fall_only & cur & ~prv);
  endfunction

  // Output enable: outputs drive unless open-drain is releasing a 1.
  function automatic logic pad_en(input logic dir, input logic od, input logic dat);
    return dir & ~(od & dat);
  endfunction

  // Pad value: open-drain pins only ever drive 0.
  function automatic logic pad_val(input logic od, input logic dat);
    return dat & ~od;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] hit
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic prv;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= 1'b0;
      else        prv <= lvl[i];
    end

    assign hit[i] = edge_hit(lvl[i], prv, fall_only[i]);

    // A fresh edge outranks a clear arriving in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ev_q[i] <= 1'b0;
      else if (hit[i]) ev_q[i] <= 1'b1;
      else if (clr[i]) ev_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  gpio_sel_e    sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] od_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      od_q  <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DIR: dir_q <= wdata;
        SEL_OD:  od_q  <= wdata;
        SEL_DAT: dat_q <= wdata;
        SEL_MSK: msk_q <= wdata;
        SEL_CTL: ctl_q <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] od_q,
  input  logic [W-1:0] dat_q,
  output logic [W-1:0] oe_r,
  output logic [W-1:0] out_r
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe_r[i]  = pad_en(dir_q[i], od_q[i], dat_q[i]);
    assign out_r[i] = pad_val(od_q[i], dat_q[i]);
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);

  localparam int MSB = NPINS - 1;

  // Everything inside uses register order: pin n lives at bit MSB-n.
  logic [NPINS-1:0] in_r, lvl_r, oe_r, out_r;
  logic [NPINS-1:0] dir_q, od_q, dat_q, msk_q, ctl_q, ev_q, hit_w, clr_w;
  logic             upper_ok;
  gpio_sel_e        sel_w;

  if (ADDR_W > 8) begin : g_wide_addr
    assign upper_ok = ~|bus_addr[ADDR_W-1:8];
  end else begin : g_narrow_addr
    assign upper_ok = 1'b1;
  end

  assign sel_w = upper_ok ? decode_sel(8'(bus_addr)) : SEL_NONE;

  for (genvar n = 0; n < NPINS; n++) begin : g_order
    assign in_r[MSB-n] = pad_in[n];
    assign pad_oe[n]   = oe_r[MSB-n];
    assign pad_out[n]  = out_r[MSB-n];
  end

  gpio_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (in_r),
    .q    (lvl_r)
  );

  gpio_regfile #(.W(NPINS)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (bus_wr),
    .sel  (sel_w),
    .wdata(bus_wdata),
    .dir_q(dir_q),
    .od_q (od_q),
    .dat_q(dat_q),
    .msk_q(msk_q),
    .ctl_q(ctl_q)
  );

  assign clr_w = (bus_wr && sel_w == SEL_EVT) ? bus_wdata : '0;

  gpio_edge_bank #(.W(NPINS)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl_r),
    .fall_only(ctl_q),
    .clr      (clr_w),
    .ev_q     (ev_q),
    .hit      (hit_w)
  );

  gpio_pad_drive #(.W(NPINS)) u_drive (
    .dir_q(dir_q),
    .od_q (od_q),
    .dat_q(dat_q),
    .oe_r (oe_r),
    .out_r(out_r)
  );

  always_comb begin
    case (sel_w)
      SEL_DIR: bus_rdata = dir_q;
      SEL_OD:  bus_rdata = od_q;
      SEL_DAT: bus_rdata = (dir_q & dat_q) | (~dir_q & lvl_r);
      SEL_EVT: bus_rdata = ev_q;
      SEL_MSK: bus_rdata = msk_q;
      SEL_CTL: bus_rdata = ctl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(ev_q & msk_q);

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input gpio_sel_e    sel_w,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] od_q,
  input logic [W-1:0] dat_q,
  input logic [W-1:0] ev_q,
  input logic [W-1:0] hit_w,
  input logic [W-1:0] oe_r,
  input logic         irq
);

  // R3
  input_pin_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_r & ~dir_q) == '0);

  // R4
  open_drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & dir_q & dat_q & oe_r) == '0);

  // R8
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_w == SEL_EVT) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // R9
  edge_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w != '0) |=> ((ev_q & $past(hit_w)) == $past(hit_w)));

  // R10
  clear_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_w == SEL_EVT && (&bus_wdata) && hit_w == '0) |=> !irq);

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.W(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .sel_w    (sel_w),
  .bus_wdata(bus_wdata),
  .dir_q    (dir_q),
  .od_q     (od_q),
  .dat_q    (dat_q),
  .ev_q     (ev_q),
  .hit_w    (hit_w),
  .oe_r     (oe_r),
  .irq      (irq)
);

// File: tb/gpio_ctrl_test.sv
`timescale 1ns/100ps
module gpio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // Reverse pin order <-> register order (R2).
  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31 - i];
    return r;
  endfunction

  // Behavioural model in register order, plus a history of pad samples.
  logic [31:0] m_dir, m_od, m_dat, m_ev, m_msk, m_ctl;
  logic [31:0] hist[$];

  function automatic logic [31:0] level_now();
    return flip(hist[hist.size() - 2]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_od = 0; m_dat = 0; m_ev = 0; m_msk = 0; m_ctl = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] cur, old, ev_hit, clr;
      cur = flip(hist[hist.size() - 2]);
      old = flip(hist[hist.size() - 3]);
      ev_hit = 0;
      for (int i = 0; i < 32; i++) begin
        if (old[i] && !cur[i]) ev_hit[i] = 1'b1;
        if (!old[i] && cur[i] && !m_ctl[i]) ev_hit[i] = 1'b1;
      end
      clr = (bus_wr && bus_addr == 8'h0C) ? bus_wdata : 32'h0;
      m_ev = (m_ev & ~clr) | ev_hit;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_dir = bus_wdata;
          8'h04: m_od  = bus_wdata;
          8'h08: m_dat = bus_wdata;
          8'h10: m_msk = bus_wdata;
          8'h14: m_ctl = bus_wdata;
          default: ;
        endcase
      end
      hist.push_back(pad_in);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rdata(input logic [7:0] a);
    case (a)
      8'h00: return m_dir;
      8'h04: return m_od;
      8'h08: return (m_dir & m_dat) | (~m_dir & level_now());
      8'h0C: return m_ev;
      8'h10: return m_msk;
      8'h14: return m_ctl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_all();
    string tag;
    case (bus_addr)
      8'h08:   tag = "R5 data read";
      8'h0C:   tag = "R6 R8 event read";
      default: tag = "R11 register read";
    endcase
    chk("R3 pad_oe", pad_oe, flip(m_dir & ~(m_od & m_dat)));
    chk("R4 pad_out", pad_out, flip(m_dat & ~m_od));
    chk("R10 irq", {31'b0, irq}, {31'b0, |(m_ev & m_msk)});
    chk(tag, bus_rdata, model_rdata(bus_addr));
  endtask

  // Drive one cycle of stimulus, compare before the edge, then advance.
  task automatic tick(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] p);
    bus_wr = wr; bus_addr = a; bus_wdata = d; pad_in = p;
    #1;
    compare_all();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Read with an explicit expected value in addition to the model.
  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_wr = 1'b0; bus_addr = a; bus_wdata = 0;
    #1;
    chk(tag, bus_rdata, exp);
    compare_all();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1 pad_oe reset", pad_oe, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 8; a++) read_chk("R1 register reset", 8'(a * 4), 32'h0);

    // R2 R3: pins 0..3 outputs, pins 0 and 2 high
    tick(1, 8'h00, 32'hF000_0000, 0);
    tick(1, 8'h08, 32'hA000_0000, 0);
    #1;
    chk("R2 R3 pad_oe pins0-3", pad_oe, 32'h0000_000F);
    chk("R2 R3 pad_out pins0,2", pad_out, 32'h0000_0005);
    read_chk("R11 dir readback", 8'h00, 32'hF000_0000);

    // R4: open-drain on pins 1 and 2
    tick(1, 8'h04, 32'h6000_0000, 0);
    #1;
    chk("R4 open-drain oe", pad_oe, 32'h0000_000B);
    chk("R4 open-drain out", pad_out, 32'h0000_0001);

    // R5 R2 R6: pin 31 rises; data bit 0 after two edges, event after three
    tick(0, 8'h08, 0, 32'h8000_0000);
    tick(0, 8'h08, 0, 32'h8000_0000);
    read_chk("R5 R2 input level", 8'h08, 32'hA000_0001);
    read_chk("R6 rise latched", 8'h0C, 32'h0000_0001);
    tick(1, 8'h10, 32'h0000_0001, 32'h8000_0000);
    #1;
    chk("R10 irq masked on", {31'b0, irq}, 32'h1);

    // R8: write zeros leave, write one clears
    tick(1, 8'h0C, 32'hFFFF_FFFE, 32'h8000_0000);
    read_chk("R8 zero write keeps", 8'h0C, 32'h0000_0001);
    tick(1, 8'h0C, 32'h0000_0001, 32'h8000_0000);
    read_chk("R8 one write clears", 8'h0C, 32'h0);
    #1;
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);

    // R6: fall in any-edge mode
    for (int k = 0; k < 3; k++) tick(0, 8'h0C, 0, 32'h0);
    read_chk("R6 fall latched", 8'h0C, 32'h0000_0001);
    tick(1, 8'h0C, 32'hFFFF_FFFF, 0);

    // R7: pin 20 (bit 11) falling-only
    tick(1, 8'h14, 32'h0000_0800, 0);
    for (int k = 0; k < 3; k++) tick(0, 8'h0C, 0, 32'h0010_0000);
    read_chk("R7 rise ignored", 8'h0C, 32'h0);
    for (int k = 0; k < 3; k++) tick(0, 8'h0C, 0, 32'h0);
    read_chk("R7 fall latched", 8'h0C, 32'h0000_0800);
    tick(1, 8'h0C, 32'h0000_0800, 0);

    // R9: pin 5 (bit 26) edge lands in the clear cycle
    tick(0, 8'h0C, 0, 32'h0000_0020);
    tick(0, 8'h0C, 0, 32'h0000_0020);
    tick(1, 8'h0C, 32'h0400_0000, 32'h0000_0020);
    read_chk("R9 edge beats clear", 8'h0C, 32'h0400_0000);
    tick(1, 8'h0C, 32'hFFFF_FFFF, 32'h0000_0020);

    // R11: unmapped offsets
    tick(1, 8'h18, 32'hFFFF_FFFF, 32'h0000_0020);
    tick(1, 8'h02, 32'hFFFF_FFFF, 32'h0000_0020);
    read_chk("R11 unmapped read", 8'h18, 32'h0);
    read_chk("R11 dir untouched", 8'h00, 32'hF000_0000);

    // Random traffic against the model
    p = 32'h0000_0020;
    for (int k = 0; k < 2000; k++) begin
      logic        w;
      logic [7:0]  a;
      w = ($urandom % 3) == 0;
      a = 8'(($urandom % 8) * 4);
      if (($urandom % 4) == 0) p = p ^ (32'h1 << ($urandom % 32));
      tick(w, a, $urandom, p);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule